// File: doc/BRIEF.md
# Potentiometer Register Bank Controller

This block keeps the register state for four digitally set wiper channels. Each channel owns one volatile wiper register, which drives the tap position, and four stored data registers arranged in rows. A single status register picks whether channel accesses reach the wiper registers or one row of data registers. The block sits behind the byte layer of a serial slave. It takes an address byte, write data bytes, read requests and a STOP indication, and it answers read requests one cycle later.

Stored registers are modelled with flops. A commit into them is gated by the write-protect input and is followed by a self-timed busy window. While that window runs, all serial and store requests are ignored, so the slave can withhold its acknowledge. A separate store request from an up/down step interface copies one channel's wiper into data row 0. Selecting a row, reading a data register, writing a data register and closing a page write all reload wiper registers. At reset, row 0 of every channel is recalled into the wipers.

Top module: `potbank_ctrl`

## Requirements
- R1: Address byte bits 2:0 set the register pointer: values 0 to 3 are channels 0 to 3, value 7 is the status register, and values 4 to 6 are unused: data written there changes nothing, and a read there returns 0x00.
- R2: The status register resets to 0x00. Bit 0 selects the data registers when 1 and the wiper registers when 0, bits 2:1 give the row 0 to 3, and bits 7:3 are always read back as 0.
- R3: A status write with bit 0 set copies data row bits 2:1 of every channel into that channel's wiper in the same cycle the status changes; a status write with bit 0 clear loads no wiper.
- R4: With status bit 0 clear, a data byte to a channel loads that wiper only, causes no busy period, and advances the pointer by one, wrapping from 3 to 0.
- R5: With status bit 0 set, a read of a channel returns that channel's data register in the selected row on rd_data_o in the cycle after the request, and loads the same value into the wiper.
- R6: With status bit 0 set, each data byte is staged for the pointed channel, loads that wiper, and advances the pointer with wrap from 3 to 0; a later byte to the same channel replaces the earlier one, and the staged bytes reach the selected row at STOP.
- R7: At a STOP that closes a staged write, channels that received no byte reload their wiper from the selected row.
- R8: If write protect is low at the STOP, the staged bytes are dropped, the data registers keep their values and no busy period starts.
- R9: A commit raises busy_o for exactly BUSY_CYCLES cycles; while busy_o is high, address bytes, data bytes, reads, STOPs and store requests are all ignored.
- R10: After reset, data register row r of channel c holds INIT_SEED + 4c + r (mod 256), and the wipers hold row 0 once busy_o first falls.
- R11: A store request with write protect high, status bits 2:1 equal to 0 and busy_o low writes the wiper of channel ud_sel_i into its row 0 and starts a busy period; otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write protect, high allows commits |
| addr_vld_i | input | 1 | byte_i holds an address byte |
| wdat_vld_i | input | 1 | byte_i holds an acknowledged write data byte |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Request the byte at the pointer |
| stop_i | input | 1 | STOP seen on the bus |
| ud_store_i | input | 1 | Up/down store request |
| ud_sel_i | input | 2 | Channel for the store request |
| rd_data_o | output | 8 | Read data, valid the cycle after rd_req_i |
| busy_o | output | 1 | Recall or commit cycle running |
| wiper_o | output | 32 | Wiper registers, channel c at bits 8c+7:8c |

## Verification
A wrong pointer or status value shows up one cycle later as a wrong wiper on wiper_o or a wrong byte on rd_data_o, because every row selection, data read and data write moves a wiper. A staged byte lost or misplaced in the buffer stays hidden until the STOP, then shows as a wrong refresh at once and as wrong stored data on the next read of that row. A busy counter off by one shows directly as a changed busy_o width, and a missing busy gate shows as wiper or read-data movement during the window.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CH_N    = 4;
  localparam int unsigned ROWS_N  = 4;
  localparam int unsigned SR_ADDR = 7;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CH_W    = $clog2(CH_N);
  localparam int unsigned ROW_W   = $clog2(ROWS_N);

  typedef logic [DATA_W-1:0] byte_t;

  function automatic byte_t init_value(int unsigned ch, int unsigned row, byte_t seed);
    return seed + byte_t'(ch * ROWS_N + row);
  endfunction
endpackage

// File: rtl/potbank_ptr.sv
module potbank_ptr #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CH_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;

  assign ptr_en = load_i | adv_i;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = load_val_i;
    end else if (adv_i) begin
      ptr_d = (ptr_q == ADDR_W'(CH_N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/potbank_stage_buf.sv
module potbank_stage_buf #(
  parameter int unsigned CH_N   = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CH_W  = $clog2(CH_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [CH_W-1:0]          idx_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     clr_i,
  output logic [CH_N*DATA_W-1:0]   data_o,
  output logic [CH_N-1:0]          mask_o
);
  logic [DATA_W-1:0] slot_q [CH_N];
  logic [CH_N-1:0]   mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr_i) begin
      mask_d = '0;
    end else if (we_i) begin
      mask_d[idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (clr_i | we_i) begin
      mask_q <= mask_d;
    end
  end

  for (genvar s = 0; s < CH_N; s++) begin : g_slot
    logic slot_en;
    assign slot_en = we_i & (idx_i == CH_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (slot_en) begin
        slot_q[s] <= data_i;
      end
    end
    assign data_o[s*DATA_W +: DATA_W] = slot_q[s];
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/potbank_busy_timer.sv
module potbank_busy_timer #(
  parameter int unsigned CYCLES = 1250000,
  localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = start_i | (cnt_q != '0);

  always_comb begin
    if (start_i) begin
      cnt_d = CNT_W'(CYCLES);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/potbank_ctrl.sv
module potbank_ctrl
  import potbank_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1250000,
  parameter logic [7:0]  INIT_SEED   = 8'h40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wp_i,
  input  logic                   addr_vld_i,
  input  logic                   wdat_vld_i,
  input  logic [DATA_W-1:0]      byte_i,
  input  logic                   rd_req_i,
  input  logic                   stop_i,
  input  logic                   ud_store_i,
  input  logic [CH_W-1:0]        ud_sel_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   busy_o,
  output logic [CH_N*DATA_W-1:0] wiper_o
);
  localparam int unsigned SR_BITS = 1 + ROW_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  byte_t                 dr_q    [ROWS_N][CH_N];
  byte_t                 dr_d    [ROWS_N][CH_N];
  byte_t                 wiper_q [CH_N];
  byte_t                 wiper_d [CH_N];
  logic [SR_BITS-1:0]    sr_q, sr_d;
  byte_t                 rd_q, rd_d;
  logic                  recall_q;
  logic [ADDR_W-1:0]     ptr;
  logic [CH_N*DATA_W-1:0] stg_data;
  logic [CH_N-1:0]       stg_mask;
  logic                  timer_busy;
  logic [ROWS_N*CH_N*DATA_W-1:0] dr_flat;

  logic              act, nv, ptr_is_ch, ptr_is_sr;
  logic [ROW_W-1:0]  row, new_row;
  logic [CH_W-1:0]   ptr_ch;
  logic              wr_sr, wr_ch, rd_ch, stage_we, close_stg, do_commit, ud_ok, rd_en;

  assign busy_o    = recall_q | timer_busy;
  assign act       = ~busy_o;
  assign nv        = sr_q[0];
  assign row       = sr_q[ROW_W:1];
  assign new_row   = byte_i[ROW_W:1];
  assign ptr_ch    = ptr[CH_W-1:0];
  assign ptr_is_ch = (ptr < ADDR_W'(CH_N));
  assign ptr_is_sr = (ptr == ADDR_W'(SR_ADDR));

  assign wr_sr     = act & wdat_vld_i & ptr_is_sr;
  assign wr_ch     = act & wdat_vld_i & ptr_is_ch;
  assign rd_ch     = act & rd_req_i & ptr_is_ch;
  assign rd_en     = act & rd_req_i;
  assign stage_we  = wr_ch & nv;
  assign close_stg = act & stop_i & (|stg_mask);
  assign do_commit = close_stg & wp_i;
  assign ud_ok     = act & ud_store_i & ~stop_i & wp_i & (row == '0);

  potbank_ptr #(.ADDR_W(ADDR_W), .CH_N(CH_N)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (act & addr_vld_i),
    .load_val_i (byte_i[ADDR_W-1:0]),
    .adv_i      (wr_ch | rd_ch),
    .ptr_o      (ptr)
  );

  potbank_stage_buf #(.CH_N(CH_N), .DATA_W(DATA_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_i   (stage_we),
    .idx_i  (ptr_ch),
    .data_i (byte_i),
    .clr_i  (act & stop_i),
    .data_o (stg_data),
    .mask_o (stg_mask)
  );

  potbank_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (do_commit | ud_ok),
    .busy_o  (timer_busy)
  );

  // next state
  always_comb begin
    sr_d = sr_q;
    if (wr_sr) sr_d = byte_i[SR_BITS-1:0];

    rd_d = rd_q;
    if (rd_en) begin
      if (ptr_is_sr)      rd_d = byte_t'(sr_q);
      else if (ptr_is_ch) rd_d = nv ? dr_q[row][ptr_ch] : wiper_q[ptr_ch];
      else                rd_d = '0;
    end

    for (int r = 0; r < ROWS_N; r++) begin
      for (int c = 0; c < CH_N; c++) begin
        dr_d[r][c] = dr_q[r][c];
        if (do_commit && stg_mask[c] && (ROW_W'(r) == row))
          dr_d[r][c] = stg_data[c*DATA_W +: DATA_W];
        if (ud_ok && (r == 0) && (CH_W'(c) == ud_sel_i))
          dr_d[r][c] = wiper_q[c];
      end
    end

    for (int c = 0; c < CH_N; c++) begin
      wiper_d[c] = wiper_q[c];
      if (recall_q)
        wiper_d[c] = dr_q[0][c];
      else if (wr_sr && byte_i[0])
        wiper_d[c] = dr_q[new_row][c];
      else if (wr_ch && (ptr_ch == CH_W'(c)))
        wiper_d[c] = byte_i;
      else if (rd_ch && nv && (ptr_ch == CH_W'(c)))
        wiper_d[c] = dr_q[row][c];
      else if (close_stg && !stg_mask[c])
        wiper_d[c] = dr_q[row][c];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sr_q     <= '0;
      rd_q     <= '0;
      recall_q <= 1'b1;
    end else begin
      recall_q <= 1'b0;
      if (wr_sr) sr_q <= sr_d;
      if (rd_en) rd_q <= rd_d;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) wiper_q[c] <= '0;
      else            wiper_q[c] <= wiper_d[c];
    end
    for (genvar r = 0; r < ROWS_N; r++) begin : g_row
      logic dr_en;
      assign dr_en = do_commit | ud_ok;
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)  dr_q[r][c] <= init_value(c, r, INIT_SEED);
        else if (dr_en)  dr_q[r][c] <= dr_d[r][c];
      end
      assign dr_flat[(r*CH_N+c)*DATA_W +: DATA_W] = dr_q[r][c];
    end
    assign wiper_o[c*DATA_W +: DATA_W] = wiper_q[c];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/potbank_ctrl_chk.sv
module potbank_ctrl_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CH_N    = 4,
  parameter int unsigned ROWS_N  = 4,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SR_ADDR = 7
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wp_i,
  input logic                          wdat_vld_i,
  input logic [DATA_W-1:0]             byte_i,
  input logic                          rd_req_i,
  input logic                          stop_i,
  input logic                          ud_store_i,
  input logic [DATA_W-1:0]             rd_data_o,
  input logic                          busy_o,
  input logic [CH_N*DATA_W-1:0]        wiper_o,
  input logic [ADDR_W-1:0]             ptr,
  input logic [ROWS_N*CH_N*DATA_W-1:0] dr_flat
);
  logic [DATA_W-1:0] row_pick_ch0;
  logic              ptr_unused;

  assign row_pick_ch0 = dr_flat[int'(byte_i[2:1])*CH_N*DATA_W +: DATA_W];
  assign ptr_unused   = (ptr >= ADDR_W'(CH_N)) && (ptr != ADDR_W'(SR_ADDR));

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !busy_o && ptr_unused) |=> (rd_data_o == '0)); // R1

  AST_ROW_COPY_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_vld_i && !busy_o && (ptr == ADDR_W'(SR_ADDR)) && byte_i[0])
      |=> (wiper_o[DATA_W-1:0] == $past(row_pick_ch0))); // R3

  AST_DATA_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_vld_i && !busy_o && !stop_i && !ud_store_i) |=> !busy_o); // R4

  AST_BUSY_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wp_i)); // R8

  AST_STORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(dr_flat)); // R9

  AST_STORE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ud_store_i && !wp_i && !busy_o) |=> !busy_o); // R11
endmodule

bind potbank_ctrl potbank_ctrl_chk #(
  .DATA_W (DATA_W),
  .CH_N   (CH_N),
  .ROWS_N (ROWS_N),
  .ADDR_W (ADDR_W),
  .SR_ADDR(SR_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_i       (wp_i),
  .wdat_vld_i (wdat_vld_i),
  .byte_i     (byte_i),
  .rd_req_i   (rd_req_i),
  .stop_i     (stop_i),
  .ud_store_i (ud_store_i),
  .rd_data_o  (rd_data_o),
  .busy_o     (busy_o),
  .wiper_o    (wiper_o),
  .ptr        (ptr),
  .dr_flat    (dr_flat)
);

// File: tb/potbank_ctrl_test.sv
module potbank_ctrl_test;
  localparam int BUSY = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_i = 1'b1;
  logic        addr_vld_i = 1'b0;
  logic        wdat_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        rd_req_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        ud_store_i = 1'b0;
  logic [1:0]  ud_sel_i = '0;
  logic [7:0]  rd_data_o;
  logic        busy_o;
  logic [31:0] wiper_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  potbank_ctrl #(.BUSY_CYCLES(BUSY), .INIT_SEED(8'h40)) uut (
    .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .addr_vld_i(addr_vld_i),
    .wdat_vld_i(wdat_vld_i), .byte_i(byte_i), .rd_req_i(rd_req_i),
    .stop_i(stop_i), .ud_store_i(ud_store_i), .ud_sel_i(ud_sel_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o), .wiper_o(wiper_o)
  );

  function automatic logic [7:0] initv(int c, int r);
    return 8'h40 + 8'(c * 4 + r);
  endfunction

  function automatic logic [7:0] wip(int c);
    return wiper_o[c*8 +: 8];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_addr(logic [7:0] a);
    @(negedge clk); addr_vld_i = 1'b1; byte_i = a;
    @(negedge clk); addr_vld_i = 1'b0;
  endtask

  task automatic send_data(logic [7:0] d);
    @(negedge clk); wdat_vld_i = 1'b1; byte_i = d;
    @(negedge clk); wdat_vld_i = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); rd_req_i = 1'b1;
    @(negedge clk); rd_req_i = 1'b0; v = rd_data_o;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic send_store(logic [1:0] ch);
    @(negedge clk); ud_store_i = 1'b1; ud_sel_i = ch;
    @(negedge clk); ud_store_i = 1'b0;
  endtask

  task automatic write_sr(logic [7:0] v);
    send_addr(8'h07); send_data(v);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R10 busy after recall", 32'(busy_o), 0);
    for (int c = 0; c < 4; c++) chk("R10 recalled wiper", 32'(wip(c)), 32'(initv(c, 0)));
    send_addr(8'h07); do_read(v);
    chk("R2 status reset value", 32'(v), 32'h00);
  endtask

  task automatic t_volatile();
    send_addr(8'h00); send_data(8'h11); send_data(8'h22);
    chk("R4 wiper0 write", 32'(wip(0)), 32'h11);
    chk("R4 wiper1 after advance", 32'(wip(1)), 32'h22);
    chk("R4 no busy", 32'(busy_o), 0);
    send_addr(8'h03); send_data(8'h33); send_data(8'h44);
    chk("R4 wiper3 write", 32'(wip(3)), 32'h33);
    chk("R4 wrap to channel 0", 32'(wip(0)), 32'h44);
  endtask

  task automatic t_status();
    logic [7:0] v;
    write_sr(8'hFD);
    for (int c = 0; c < 4; c++) chk("R3 row 2 copied", 32'(wip(c)), 32'(initv(c, 2)));
    send_addr(8'h07); do_read(v);
    chk("R2 reserved bits read 0", 32'(v), 32'h05);
    write_sr(8'h06);
    chk("R3 bit0 clear no copy", 32'(wip(0)), 32'(initv(0, 2)));
  endtask

  task automatic t_protect_read();
    logic [7:0] v;
    write_sr(8'h03);
    chk("R3 row 1 copied", 32'(wip(3)), 32'(initv(3, 1)));
    wp_i = 1'b0;
    send_addr(8'h01); send_data(8'h5A);
    chk("R6 staged byte on wiper", 32'(wip(1)), 32'h5A);
    send_stop();
    chk("R8 no busy when protected", 32'(busy_o), 0);
    wp_i = 1'b1;
    send_addr(8'h01); do_read(v);
    chk("R8 data register kept", 32'(v), 32'(initv(1, 1)));
    chk("R5 read loads wiper", 32'(wip(1)), 32'(initv(1, 1)));
  endtask

  task automatic t_page();
    logic [7:0] v;
    int n;
    logic [7:0] exp_row [4] = '{8'hA2, 8'hA3, 8'hA4, 8'hA1};
    write_sr(8'h05);
    send_addr(8'h02);
    for (int i = 0; i < 5; i++) send_data(8'hA0 + 8'(i));
    for (int c = 0; c < 4; c++) chk("R6 page wiper", 32'(wip(c)), 32'(exp_row[c]));
    send_stop();
    chk("R9 busy after commit", 32'(busy_o), 1);
    wait_idle(n);
    chk("R9 busy length", 32'(n), 32'(BUSY));
    send_addr(8'h00);
    for (int c = 0; c < 4; c++) begin
      do_read(v);
      chk("R6 committed page read back", 32'(v), 32'(exp_row[c]));
    end
  endtask

  task automatic t_refresh_busy();
    logic [7:0] v;
    int n;
    write_sr(8'h07);
    wp_i = 1'b0;
    send_addr(8'h00); send_data(8'h77); send_stop();
    chk("R8 discarded byte kept on wiper", 32'(wip(0)), 32'h77);
    wp_i = 1'b1;
    send_addr(8'h01); send_data(8'h88); send_stop();
    chk("R7 unwritten wiper refreshed", 32'(wip(0)), 32'(initv(0, 3)));
    chk("R7 written wiper kept", 32'(wip(1)), 32'h88);
    chk("R7 other wiper refreshed", 32'(wip(2)), 32'(initv(2, 3)));
    chk("R9 busy started", 32'(busy_o), 1);
    send_addr(8'h02); do_read(v);
    chk("R9 read ignored while busy", 32'(v), 32'hA1);
    send_data(8'h12);
    chk("R9 data ignored while busy", 32'(wip(2)), 32'(initv(2, 3)));
    wait_idle(n);
    send_addr(8'h01); do_read(v);
    chk("R6 single byte committed", 32'(v), 32'h88);
  endtask

  task automatic t_store();
    int n;
    write_sr(8'h00);
    send_addr(8'h03); send_data(8'h3C);
    send_store(2'd3);
    chk("R11 store starts busy", 32'(busy_o), 1);
    wait_idle(n);
    write_sr(8'h01);
    chk("R11 stored wiper in row 0", 32'(wip(3)), 32'h3C);
    chk("R11 other channel row 0 kept", 32'(wip(0)), 32'(initv(0, 0)));
    write_sr(8'h02);
    send_store(2'd2);
    chk("R11 store rejected for row 1", 32'(busy_o), 0);
    write_sr(8'h00);
    wp_i = 1'b0;
    send_store(2'd1);
    chk("R11 store rejected when protected", 32'(busy_o), 0);
    wp_i = 1'b1;
  endtask

  task automatic t_unused();
    logic [7:0] v;
    logic [7:0] exp_w [4] = '{8'h40, 8'h44, 8'h48, 8'h3C};
    send_addr(8'h05); send_data(8'h99);
    for (int c = 0; c < 4; c++) chk("R1 unused address no effect", 32'(wip(c)), 32'(exp_w[c]));
    do_read(v);
    chk("R1 unused address reads zero", 32'(v), 32'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_volatile();
    t_status();
    t_protect_read();
    t_page();
    t_refresh_busy();
    t_store();
    t_unused();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule